// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers six maskable interrupt sources into one active-low interrupt line to the processor. Each source is edge-sensitive: a rising edge on its request line sets a pending latch. A six-bit mask register, written through a simple write strobe, decides which pending sources may raise the interrupt line. When several sources are pending and enabled, the lowest-numbered one wins. Source 0 is an alarm or low-voltage event, 1 is a received serial byte, 2 is a carrier-detect change, 3 is a barcode trigger, 4 is a counter overflow and 5 is an expansion-unit request.

When the processor runs its interrupt-acknowledge bus cycle, the block records the winning source at the first sampled clock. It asks for two wait states. It then drives an even 8-bit vector on the data bus, which the processor joins with its own page register to look up a 16-bit handler address in a table. The drive is released before the refresh cycle that follows. The acknowledged source's pending latch is cleared as the cycle ends, and any other pending source keeps the line asserted.

The acknowledge sequencer has five states. `ACK_IDLE` moves to `ACK_WAIT1` when `inta_i` is sampled high, and records the winner at that point. `ACK_WAIT1` always moves to `ACK_WAIT2`. `ACK_WAIT2` always moves to `ACK_T3`. `ACK_T3` always moves to `ACK_RELEASE`, and clears the recorded source's pending latch. `ACK_RELEASE` stays put while `inta_i` is high and returns to `ACK_IDLE` once it is sampled low.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_n_o` is 1, `wait_o` is 0, `vec_oe_o` is 0, `vec_o` is 0, and every mask bit is set, so all sources are blocked.
- R2: A 0-to-1 transition on `req_i[i]` sets pending bit i. A request held high after its pending bit has been cleared does not set it again.
- R3: `irq_n_o` is 0 exactly when some source is pending with its mask bit clear. Mask write data bit i controls source i, and 1 means blocked. A blocked pending source never wins an acknowledge.
- R4: When several enabled sources are pending, the lowest index wins.
- R5: The vector for source i is F0h + 2*i: F0h, F2h, F4h, F6h, F8h or FAh. It is always even.
- R6: `wait_o` is high for exactly two clock periods. These are the two cycles right after the clock edge that first samples `inta_i` high.
- R7: `vec_oe_o` is high for exactly three cycles: the two wait cycles and the following cycle. It is low from the next cycle on, before refresh. While `vec_oe_o` is low, `vec_o` is 0.
- R8: The winner is recorded when the acknowledge starts. A higher-priority edge that arrives during the cycle does not change the vector being driven.
- R9: The acknowledged source's pending bit clears at the end of the cycle. Other pending sources stay latched and keep `irq_n_o` low.
- R10: An acknowledge with no enabled pending source still inserts the two wait states. It never drives the bus and changes no pending bit.
- R11: Edges that arrive while a source is masked are still latched. Clearing the mask bit then pulls `irq_n_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 6 | Interrupt request lines, rising-edge sensitive |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 6 | Mask write data, 1 blocks the source |
| inta_i | input | 1 | High for the whole interrupt-acknowledge bus cycle |
| irq_n_o | output | 1 | Active-low interrupt to the processor |
| vec_o | output | 8 | Vector onto the data bus, 0 when not driving |
| vec_oe_o | output | 1 | Data-bus drive enable for the vector |
| wait_o | output | 1 | Wait-state request |

## Verification
Assertions check the following on every cycle:
- a wait request always lasts exactly two cycles;
- a driven vector is always even and holds steady while the drive lasts;
- the bus reads zero whenever it is not driven;
- a rising request edge always sets its pending latch;
- a clear without a fresh edge always empties it;
- the priority pick never passes over a lower-indexed active source.

Only the bench scenarios can show the rest:
- the exact vector each source produces;
- that a winner recorded at the start survives a higher-priority edge during the cycle;
- that other sources stay pending across an acknowledge;
- that masked edges are remembered;
- that a spurious acknowledge leaves the bus undriven.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;

    typedef enum logic [2:0] {
        ACK_IDLE,
        ACK_WAIT1,
        ACK_WAIT2,
        ACK_T3,
        ACK_RELEASE
    } ack_state_e;

    // Vector code for a source index: base plus a fixed even step.
    function automatic logic [7:0] vector_for(input int unsigned idx,
                                              input logic [7:0]  base,
                                              input int unsigned step);
        return base + 8'(idx * step);
    endfunction

endpackage

// File: rtl/vic_pending_bank.sv
`timescale 1ns/1ps
module vic_pending_bank #(
    parameter int unsigned NUM_SRC = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic prev_q;
        logic pend_q;

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= req_i[g];
                // A fresh edge wins over a clear in the same cycle.
                if (req_i[g] && !prev_q) begin
                    pend_q <= 1'b1;
                end else if (clr_i[g]) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign pend_o[g] = pend_q;

        assert_edge_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(req_i[g]) |=> pend_o[g]);

        assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[g] && !$rose(req_i[g])) |=> !pend_o[g]);
    end

endmodule

// File: rtl/vic_prio_pick.sv
`timescale 1ns/1ps
module vic_prio_pick #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] active_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the lowest priority upward so the lowest index is kept last.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (valid_o) begin
            assert_lowest_wins_R4: assert ((active_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0);
            assert_winner_active_R4: assert (active_i[idx_o]);
        end
    end

endmodule

// File: rtl/vic_ack_fsm.sv
`timescale 1ns/1ps
module vic_ack_fsm
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 6,
    parameter int unsigned IDX_W    = 3,
    parameter logic [7:0]  VEC_BASE = 8'hF0,
    parameter int unsigned VEC_STEP = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               inta_i,
    input  logic               win_valid_i,
    input  logic [IDX_W-1:0]   win_idx_i,
    output logic               wait_o,
    output logic               oe_o,
    output logic [7:0]         vec_o,
    output logic [NUM_SRC-1:0] clr_o
);

    ack_state_e       state_q, state_d;
    logic [IDX_W-1:0] held_idx_q;
    logic             held_valid_q;
    logic             in_drive;

    // State register and winner capture.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q      <= ACK_IDLE;
            held_idx_q   <= '0;
            held_valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ACK_IDLE && inta_i) begin
                held_idx_q   <= win_idx_i;
                held_valid_q <= win_valid_i;
            end
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:    if (inta_i) state_d = ACK_WAIT1;
            ACK_WAIT1:   state_d = ACK_WAIT2;
            ACK_WAIT2:   state_d = ACK_T3;
            ACK_T3:      state_d = ACK_RELEASE;
            ACK_RELEASE: if (!inta_i) state_d = ACK_IDLE;
            default:     state_d = ACK_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        wait_o   = 1'b0;
        in_drive = 1'b0;
        clr_o    = '0;
        unique case (state_q)
            ACK_WAIT1, ACK_WAIT2: begin
                wait_o   = 1'b1;
                in_drive = 1'b1;
            end
            ACK_T3: begin
                in_drive = 1'b1;
                if (held_valid_q) clr_o = NUM_SRC'(1) << held_idx_q;
            end
            default: ;
        endcase
        oe_o  = in_drive && held_valid_q;
        vec_o = oe_o ? vector_for(32'(held_idx_q), VEC_BASE, VEC_STEP) : 8'h00;
    end

    assert_wait_two_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wait_o) |=> wait_o ##1 !wait_o);

    assert_vec_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_o |-> !vec_o[0]);

    assert_vec_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_o && $past(oe_o)) |-> $stable(vec_o));

    assert_one_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(clr_o));

    assert_release_before_refresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_o && !wait_o) |=> !oe_o);

endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl #(
    parameter int unsigned NUM_SRC  = 6,
    parameter logic [7:0]  VEC_BASE = 8'hF0,
    parameter int unsigned VEC_STEP = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic               inta_i,
    output logic               irq_n_o,
    output logic [7:0]         vec_o,
    output logic               vec_oe_o,
    output logic               wait_o
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] clr;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q <= '1;
        end else if (mask_we_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    vic_pending_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign active  = pend & ~mask_q;
    assign irq_n_o = ~|active;

    vic_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .active_i (active),
        .valid_o  (win_valid),
        .idx_o    (win_idx)
    );

    vic_ack_fsm #(
        .NUM_SRC  (NUM_SRC),
        .IDX_W    (IDX_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_ack (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .inta_i      (inta_i),
        .win_valid_i (win_valid),
        .win_idx_i   (win_idx),
        .wait_o      (wait_o),
        .oe_o        (vec_oe_o),
        .vec_o       (vec_o),
        .clr_o       (clr)
    );

    assert_quiet_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_oe_o |-> (vec_o == 8'h00));

    assert_all_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q == '1) |-> irq_n_o);

    assert_no_drive_without_winner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wait_o) && !vec_oe_o |=> !vec_oe_o);

endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] req;
    logic       mask_we;
    logic [5:0] mask_wdata;
    logic       inta;
    logic       irq_n;
    logic [7:0] vec;
    logic       vec_oe;
    logic       wait_r;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;
    logic [7:0]  exp_q[$];
    logic [7:0]  last_vec = 8'h00;
    logic        oe_prev  = 1'b0;

    always #4 clk = ~clk;

    vec_irq_ctrl dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_i        (req),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .inta_i       (inta),
        .irq_n_o      (irq_n),
        .vec_o        (vec),
        .vec_oe_o     (vec_oe),
        .wait_o       (wait_r)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected vector when a drive begins, checks hold after.
    always @(negedge clk) begin
        if (rst_n) begin
            if (vec_oe && !oe_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected drive", vec, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    check(vec == e, "R5 vector", vec, e);
                    last_vec = vec;
                end
            end else if (vec_oe && oe_prev) begin
                check(vec == last_vec, "R8 vector held", vec, last_vec);
            end
        end
        oe_prev <= vec_oe;
    end

    task automatic pulse(input logic [5:0] bits);
        @(negedge clk) req = req | bits;
        @(negedge clk) req = req & ~bits;
    endtask

    task automatic wr_mask(input logic [5:0] v);
        @(negedge clk) begin mask_we = 1'b1; mask_wdata = v; end
        @(negedge clk) mask_we = 1'b0;
    endtask

    // Driver: pushes the expected vector and runs one acknowledge cycle.
    task automatic ack(input bit valid, input logic [7:0] ev, input logic [5:0] mid);
        if (valid) exp_q.push_back(ev);
        @(negedge clk) inta = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(wait_r == (c < 2), "R6 wait window", wait_r, (c < 2));
            check(vec_oe == (valid && c < 3), "R7 drive window", vec_oe, (valid && c < 3));
            if (!vec_oe) check(vec == 8'h00, "R7 idle bus", vec, 0);
            if (c == 0) req = req | mid;
            if (c == 3) inta = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; req = '0; mask_we = 1'b0; mask_wdata = '0; inta = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        check(vec_oe == 1'b0, "R1 vec_oe", vec_oe, 0);
        check(wait_r == 1'b0, "R1 wait", wait_r, 0);
        check(vec == 8'h00, "R1 vec", vec, 0);

        // R11 / R3: edge latched while masked, unmasking raises the line
        pulse(6'b001000);
        @(negedge clk);
        check(irq_n == 1'b1, "R3 masked source silent", irq_n, 1);
        wr_mask(6'b000000);
        check(irq_n == 1'b0, "R11 unmask raises irq", irq_n, 0);
        ack(1'b1, 8'hF6, '0);
        check(irq_n == 1'b1, "R9 acked source cleared", irq_n, 1);

        // R2: a held level does not retrigger
        @(negedge clk) req[2] = 1'b1;
        repeat (2) @(negedge clk);
        check(irq_n == 1'b0, "R2 edge sets pending", irq_n, 0);
        ack(1'b1, 8'hF4, '0);
        repeat (3) @(negedge clk);
        check(irq_n == 1'b1, "R2 level no retrigger", irq_n, 1);
        req[2] = 1'b0;

        // R4 / R9: simultaneous sources, lowest index first, other stays
        @(negedge clk) req = 6'b100010;
        @(negedge clk) req = '0;
        ack(1'b1, 8'hF2, '0);
        check(irq_n == 1'b0, "R9 other source still pending", irq_n, 0);
        ack(1'b1, 8'hFA, '0);
        check(irq_n == 1'b1, "R9 all served", irq_n, 1);

        // R8: higher-priority edge during the cycle does not alter the vector
        pulse(6'b010000);
        ack(1'b1, 8'hF8, 6'b000001);
        check(irq_n == 1'b0, "R8 late source latched", irq_n, 0);
        @(negedge clk) req = '0;
        ack(1'b1, 8'hF0, '0);
        check(irq_n == 1'b1, "R8 late source served", irq_n, 1);

        // R10: spurious acknowledge
        ack(1'b0, 8'h00, '0);
        check(irq_n == 1'b1, "R10 no pending change", irq_n, 1);

        // R3: masked pending source does not win
        wr_mask(6'b000001);
        pulse(6'b000101);
        ack(1'b1, 8'hF4, '0);
        check(irq_n == 1'b1, "R3 masked pending not signalled", irq_n, 1);
        wr_mask(6'b000000);
        check(irq_n == 1'b0, "R11 masked edge remembered", irq_n, 0);
        ack(1'b1, 8'hF0, '0);

        // R5: every source's vector
        for (int i = 0; i < 6; i++) begin
            pulse(6'(1 << i));
            ack(1'b1, 8'hF0 + 8'(2 * i), '0);
        end
        check(irq_n == 1'b1, "R5 sweep leaves nothing pending", irq_n, 1);
        check(exp_q.size() == 0, "R7 every expected drive seen", exp_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

endmodule